// File: doc/BRIEF.md
# Pen Interrupt Gating Logic

This block produces the active-low pen interrupt pin level of a resistive touch controller, and an output-enable for that pin. It works from the raw touch comparator, the serial chip-select, a one-cycle strobe for each rising serial clock edge, the power-down bit and channel class of the command now in effect, the sleep code, a command-received strobe and the internal measurement sequencer's busy flag. The analog pull-up and the panel drivers sit outside; the block only decides the level and whether the pin is driven.

While the chip-select is high the pin reports touch directly, unless a latched sleep state holds it high or floats it. While the chip-select is low, the serial clock edges counted since the falling edge split the frame into three windows. The first window repeats the behaviour of the previous frame, taken from the power-down bit and channel class captured at the last chip-select rise. The second window covers the sampling and conversion period and forces a fixed level. The third window applies the normal rule with the current settings. In continuous readout the conversion window comes back every 16 serial clocks. When the internal sequencer is busy it owns the pin outright.

Top module: `penirq_gate`

## Requirements
- R1: While rst_n is low, pen_irq_n is 1 and pen_irq_oe is 1.
- R2: Every output is registered. The outputs in the cycle after a clock edge are computed from the inputs and state at that edge. With cs_n high, seq_busy low and no sleep latched, pen_irq_n is the inverse of touch_det (touch_det is 1 when pressed) and pen_irq_oe is 1.
- R3: With cs_n low, fewer than 5 sclk_tick pulses have been seen since cs_n went low (the first window). If the captured power-down bit is 0, pen_irq_n is the inverse of touch_det. If it is 1, pen_irq_n is 0 when the captured channel class is panel and 1 when it is not.
- R4: The second window starts at the 5th tick and lasts 15 ticks (12-bit, res8=0) or 11 ticks (8-bit, res8=1), so it ends at the 20th or 16th tick. In it, pen_irq_n is 1 when pd_bit=1. When pd_bit=0, pen_irq_n is 0 for chan_panel=1 and 1 for chan_panel=0.
- R5: After the second window and until cs_n rises (the third window), the R3 rule applies using pd_bit and chan_panel.
- R6: On each cycle where cs_n is seen rising, pd_bit and chan_panel are captured for the next frame. After reset the captured values are power-down 0 and panel class 1.
- R7: With cont_mode=1, the window pattern repeats with a period of 16 ticks. At each repeat the second window lasts 15 or 11 ticks and the third window fills the rest of the period.
- R8: A latched sleep state acts only while cs_n is high. Code 2'b01 holds pen_irq_n at 1. Code 2'b10 sets pen_irq_oe to 0 with pen_irq_n at 1. Code 2'b11 acts like 2'b00 (no sleep).
- R9: sleep_code is sampled only on a cs_n rise, and only when no sleep state is latched. A sleep state is cleared only by cmd_strobe while cs_n is low. A cs_n low period without cmd_strobe keeps the sleep state across the next rise, whatever sleep_code shows.
- R10: While seq_busy is 1, pen_irq_n follows seq_lvl and pen_irq_oe is 1, regardless of cs_n, the windows and sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_det | input | 1 | Raw touch comparator, 1 = pressed |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk_tick | input | 1 | One-cycle pulse per rising serial clock edge |
| pd_bit | input | 1 | Power-down bit of the current command |
| chan_panel | input | 1 | Current channel is a panel channel (1) or temperature/auxiliary (0) |
| res8 | input | 1 | 8-bit conversion result selected |
| cont_mode | input | 1 | Continuous readout selected |
| sleep_code | input | 2 | Sleep setting from the configuration register |
| cmd_strobe | input | 1 | One-cycle pulse when a control command is received |
| seq_busy | input | 1 | Internal measurement sequence running |
| seq_lvl | input | 1 | Pin level requested by the sequencer |
| pen_irq_n | output | 1 | Active-low pen interrupt level |
| pen_irq_oe | output | 1 | Pin drive enable, 0 = high impedance |

## Verification
The hardest case to reach is a sleep state that outlives a chip-select low period. It requires a sleep code latched at one rise and a low period with no command strobe. The stimulus then presents a different sleep_code at the next rise, so that a wrong re-sample would change the pin. A second hard case is a window boundary in continuous readout, where the conversion window recurs every 16 ticks. The stimulus holds long frames with varied tick spacing and a changing touch pattern. A bench model computes the expected level from the tick count alone, and both pin outputs are compared on every clock.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;

  typedef enum logic [1:0] {
    PH_ARM  = 2'd0,
    PH_WIN  = 2'd1,
    PH_TAIL = 2'd2
  } frame_phase_e;

  typedef enum logic [1:0] {
    SLP_NONE    = 2'd0,
    SLP_HOLD_HI = 2'd1,
    SLP_FLOAT   = 2'd2
  } sleep_e;

  function automatic sleep_e decode_sleep(input logic [1:0] code);
    case (code)
      2'b01:   decode_sleep = SLP_HOLD_HI;
      2'b10:   decode_sleep = SLP_FLOAT;
      default: decode_sleep = SLP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pirq_phase_track.sv
`timescale 1ns/1ps
module pirq_phase_track
  import pirq_pkg::*;
#(
  parameter int PH1_EDGES  = 5,
  parameter int WIN_WIDE   = 15,
  parameter int WIN_NARROW = 11,
  parameter int FRAME_LEN  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk_tick,
  input  logic         res8,
  input  logic         cont_mode,
  output frame_phase_e phase_q
);

  localparam int MAXV  = (PH1_EDGES > FRAME_LEN) ? PH1_EDGES : FRAME_LEN;
  localparam int POS_W = $clog2(MAXV + 1);

  logic [POS_W-1:0] pos_q, pos_d, pos_inc, win_len;
  frame_phase_e     phase_d;
  logic             trk_en;

  assign win_len = res8 ? POS_W'(WIN_NARROW) : POS_W'(WIN_WIDE);
  assign pos_inc = pos_q + 1'b1;
  assign trk_en  = cs_n | sclk_tick;

  always_comb begin
    phase_d = phase_q;
    pos_d   = pos_q;
    if (cs_n) begin
      phase_d = PH_ARM;
      pos_d   = '0;
    end else begin
      case (phase_q)
        PH_ARM: begin
          if (pos_inc >= POS_W'(PH1_EDGES)) begin
            phase_d = PH_WIN;
            pos_d   = '0;
          end else begin
            pos_d = pos_inc;
          end
        end
        PH_WIN: begin
          pos_d = pos_inc;
          if (pos_inc >= win_len) phase_d = PH_TAIL;
        end
        PH_TAIL: begin
          if (cont_mode) begin
            if (pos_inc >= POS_W'(FRAME_LEN)) begin
              phase_d = PH_WIN;
              pos_d   = '0;
            end else begin
              pos_d = pos_inc;
            end
          end
        end
        default: begin
          phase_d = PH_ARM;
          pos_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ARM;
      pos_q   <= '0;
    end else if (trk_en) begin
      phase_q <= phase_d;
      pos_q   <= pos_d;
    end
  end

  AST_ARM_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase_q == PH_ARM)); // R3

  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q < POS_W'(FRAME_LEN))); // R7

endmodule

// File: rtl/pirq_history.sv
`timescale 1ns/1ps
module pirq_history
  import pirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       pd_bit,
  input  logic       chan_panel,
  input  logic [1:0] sleep_code,
  input  logic       cmd_strobe,
  output logic       prev_pd_q,
  output logic       prev_panel_q,
  output sleep_e     sleep_q
);

  logic   cs_n_q;
  logic   cs_rise;
  logic   slp_clr;
  logic   slp_en;
  sleep_e sleep_d;

  assign cs_rise = cs_n & ~cs_n_q;
  assign slp_clr = ~cs_n & cmd_strobe;
  assign slp_en  = cs_rise | slp_clr;

  always_comb begin
    sleep_d = sleep_q;
    if (cs_rise) begin
      if (sleep_q == SLP_NONE) sleep_d = decode_sleep(sleep_code);
    end else if (slp_clr) begin
      sleep_d = SLP_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n_q <= 1'b1;
    else        cs_n_q <= cs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pd_q    <= 1'b0;
      prev_panel_q <= 1'b1;
    end else if (cs_rise) begin
      prev_pd_q    <= pd_bit;
      prev_panel_q <= chan_panel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sleep_q <= SLP_NONE;
    else if (slp_en) sleep_q <= sleep_d;
  end

  AST_SLEEP_HELD_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cs_n_q) |=> $stable(sleep_q)); // R9

  AST_HISTORY_ONLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_n && !cs_n_q) |=> ($stable(prev_pd_q) && $stable(prev_panel_q))); // R6

endmodule

// File: rtl/pirq_out_stage.sv
`timescale 1ns/1ps
module pirq_out_stage
  import pirq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         touch_det,
  input  logic         cs_n,
  input  frame_phase_e phase,
  input  logic         pd_bit,
  input  logic         chan_panel,
  input  logic         prev_pd,
  input  logic         prev_panel,
  input  sleep_e       sleep_st,
  input  logic         seq_busy,
  input  logic         seq_lvl,
  output logic         pen_irq_n,
  output logic         pen_irq_oe
);

  logic lvl_d, oe_d;
  logic chk_ok_q;

  always_comb begin
    lvl_d = 1'b1;
    oe_d  = 1'b1;
    if (seq_busy) begin
      lvl_d = seq_lvl;
    end else if (cs_n) begin
      case (sleep_st)
        SLP_HOLD_HI: lvl_d = 1'b1;
        SLP_FLOAT: begin
          lvl_d = 1'b1;
          oe_d  = 1'b0;
        end
        default:     lvl_d = ~touch_det;
      endcase
    end else begin
      case (phase)
        PH_ARM:  lvl_d = prev_pd ? ~prev_panel : ~touch_det;
        PH_WIN:  lvl_d = pd_bit ? 1'b1 : ~chan_panel;
        PH_TAIL: lvl_d = pd_bit ? ~chan_panel : ~touch_det;
        default: lvl_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_irq_n  <= 1'b1;
      pen_irq_oe <= 1'b1;
      chk_ok_q   <= 1'b0;
    end else begin
      pen_irq_n  <= lvl_d;
      pen_irq_oe <= oe_d;
      chk_ok_q   <= 1'b1;
    end
  end

  AST_SEQ_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_ok_q && $past(seq_busy)) |-> (pen_irq_oe && (pen_irq_n == $past(seq_lvl)))); // R10

  AST_FLOAT_ONLY_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_ok_q && !pen_irq_oe) |-> ($past(cs_n) && $past(sleep_st == SLP_FLOAT) && pen_irq_n)); // R8

  AST_WIN_PD1_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_ok_q && $past(!cs_n && !seq_busy && (phase == PH_WIN) && pd_bit)) |-> pen_irq_n); // R4

endmodule

// File: rtl/penirq_gate.sv
`timescale 1ns/1ps
module penirq_gate
  import pirq_pkg::*;
#(
  parameter int PH1_EDGES  = 5,
  parameter int WIN_WIDE   = 15,
  parameter int WIN_NARROW = 11,
  parameter int FRAME_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       touch_det,
  input  logic       cs_n,
  input  logic       sclk_tick,
  input  logic       pd_bit,
  input  logic       chan_panel,
  input  logic       res8,
  input  logic       cont_mode,
  input  logic [1:0] sleep_code,
  input  logic       cmd_strobe,
  input  logic       seq_busy,
  input  logic       seq_lvl,
  output logic       pen_irq_n,
  output logic       pen_irq_oe
);

  frame_phase_e phase;
  logic         prev_pd, prev_panel;
  sleep_e       sleep_st;

  pirq_phase_track #(
    .PH1_EDGES (PH1_EDGES),
    .WIN_WIDE  (WIN_WIDE),
    .WIN_NARROW(WIN_NARROW),
    .FRAME_LEN (FRAME_LEN)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk_tick(sclk_tick),
    .res8     (res8),
    .cont_mode(cont_mode),
    .phase_q  (phase)
  );

  pirq_history u_hist (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .pd_bit      (pd_bit),
    .chan_panel  (chan_panel),
    .sleep_code  (sleep_code),
    .cmd_strobe  (cmd_strobe),
    .prev_pd_q   (prev_pd),
    .prev_panel_q(prev_panel),
    .sleep_q     (sleep_st)
  );

  pirq_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_det (touch_det),
    .cs_n      (cs_n),
    .phase     (phase),
    .pd_bit    (pd_bit),
    .chan_panel(chan_panel),
    .prev_pd   (prev_pd),
    .prev_panel(prev_panel),
    .sleep_st  (sleep_st),
    .seq_busy  (seq_busy),
    .seq_lvl   (seq_lvl),
    .pen_irq_n (pen_irq_n),
    .pen_irq_oe(pen_irq_oe)
  );

endmodule

// File: tb/tb_penirq_gate.sv
`timescale 1ns/1ps
module tb_penirq_gate;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       touch_det, cs_n, sclk_tick, pd_bit, chan_panel, res8, cont_mode;
  logic [1:0] sleep_code;
  logic       cmd_strobe, seq_busy, seq_lvl;
  logic       pen_irq_n, pen_irq_oe;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    tcnt   = 0;
  bit    auto_touch = 1'b1;
  string cur_req = "R1";

  // reference model state
  int m_edges;
  bit m_csq, m_ppd, m_ppan;
  int m_slp;

  always #2 clk = ~clk;

  penirq_gate dut (
    .clk(clk), .rst_n(rst_n), .touch_det(touch_det), .cs_n(cs_n),
    .sclk_tick(sclk_tick), .pd_bit(pd_bit), .chan_panel(chan_panel),
    .res8(res8), .cont_mode(cont_mode), .sleep_code(sleep_code),
    .cmd_strobe(cmd_strobe), .seq_busy(seq_busy), .seq_lvl(seq_lvl),
    .pen_irq_n(pen_irq_n), .pen_irq_oe(pen_irq_oe)
  );

  function automatic int phase_of(int e, bit r8, bit cont);
    int k;
    int len;
    if (e < 5) return 0;
    k   = e - 5;
    len = r8 ? 11 : 15;
    if (cont) k = k % 16;
    return (k < len) ? 1 : 2;
  endfunction

  task automatic check2(bit exp_n, bit exp_oe);
    n_chk++;
    if (pen_irq_n !== exp_n || pen_irq_oe !== exp_oe) begin
      n_fail++;
      $display("FAIL %s: pen_irq_n/oe actual %b/%b expected %b/%b at cycle %0d",
               cur_req, pen_irq_n, pen_irq_oe, exp_n, exp_oe, tcnt);
    end
  endtask

  // one clock: predict, clock, compare, advance model
  task automatic cyc();
    bit en, eo;
    int ph;
    if (auto_touch) touch_det = ((tcnt % 3) == 0) || ((tcnt % 7) == 2);
    eo = 1'b1;
    en = 1'b1;
    if (seq_busy) en = seq_lvl;
    else if (cs_n) begin
      if (m_slp == 1) en = 1'b1;
      else if (m_slp == 2) begin en = 1'b1; eo = 1'b0; end
      else en = !touch_det;
    end else begin
      ph = phase_of(m_edges, res8, cont_mode);
      if (ph == 0)      en = m_ppd ? !m_ppan : !touch_det;
      else if (ph == 1) en = pd_bit ? 1'b1 : !chan_panel;
      else              en = pd_bit ? !chan_panel : !touch_det;
    end
    @(posedge clk);
    #1;
    check2(en, eo);
    if (cs_n) m_edges = 0;
    else if (sclk_tick) m_edges++;
    if (cs_n && !m_csq) begin
      m_ppd  = pd_bit;
      m_ppan = chan_panel;
      if (m_slp == 0) m_slp = (sleep_code == 2'b01) ? 1 : (sleep_code == 2'b10) ? 2 : 0;
    end else if (!cs_n && cmd_strobe) begin
      m_slp = 0;
    end
    m_csq = cs_n;
    tcnt++;
    @(negedge clk);
  endtask

  task automatic run_frame(string req, int nticks, int gap, bit r8, bit cont, bit pd, bit pan);
    cur_req    = req;
    res8       = r8;
    cont_mode  = cont;
    pd_bit     = pd;
    chan_panel = pan;
    cs_n       = 1'b0;
    cyc();
    for (int i = 0; i < nticks; i++) begin
      sclk_tick = 1'b1;
      cyc();
      sclk_tick = 1'b0;
      for (int g = 0; g < gap + (i % 2); g++) cyc();
    end
    cs_n = 1'b1;
    cyc();
    cyc();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    touch_det = 1'b1; cs_n = 1'b1; sclk_tick = 1'b0; pd_bit = 1'b0;
    chan_panel = 1'b1; res8 = 1'b0; cont_mode = 1'b0; sleep_code = 2'b00;
    cmd_strobe = 1'b0; seq_busy = 1'b0; seq_lvl = 1'b0;
    m_edges = 0; m_csq = 1'b1; m_ppd = 1'b0; m_ppan = 1'b1; m_slp = 0;
    // R1: reset state, with touch asserted
    cur_req = "R1";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check2(1'b1, 1'b1);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: deselected, touch reported directly
    cur_req = "R2";
    for (int i = 0; i < 20; i++) cyc();

    // R6: first frame after reset uses reset history (pd 0 -> follows touch)
    run_frame("R6", 3, 2, 1'b0, 1'b0, 1'b1, 1'b1);
    // R3: previous pd 1 with panel class -> low in first window
    run_frame("R3", 22, 1, 1'b0, 1'b0, 1'b1, 0);
    run_frame("R3", 4, 3, 1'b0, 1'b0, 1'b1, 1'b1);
    // previous pd 1 with panel class
    run_frame("R3", 4, 3, 1'b0, 1'b0, 1'b0, 1'b1);
    // R4: conversion window variants
    run_frame("R4", 24, 1, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame("R4", 24, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame("R4", 20, 2, 1'b1, 1'b0, 1'b1, 1'b1);
    run_frame("R4", 20, 1, 1'b1, 1'b0, 1'b0, 1'b1);
    // R5: third window with both pd settings
    run_frame("R5", 30, 1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_frame("R5", 30, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_frame("R5", 30, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7: continuous readout, repeating windows
    run_frame("R7", 70, 1, 1'b0, 1'b1, 1'b0, 1'b1);
    run_frame("R7", 70, 1, 1'b1, 1'b1, 1'b1, 1'b0);
    run_frame("R7", 50, 0, 1'b1, 1'b1, 1'b0, 1'b0);

    // R8: sleep code 01 latched at rise -> held high
    cur_req = "R8";
    sleep_code = 2'b01;
    cs_n = 1'b0; cyc();
    cmd_strobe = 1'b1; cyc(); cmd_strobe = 1'b0;
    cyc();
    cs_n = 1'b1;
    for (int i = 0; i < 12; i++) cyc();
    // R9: code change while deselected has no effect
    cur_req = "R9";
    sleep_code = 2'b10;
    for (int i = 0; i < 8; i++) cyc();
    // R9: low period without command keeps sleep 01
    cs_n = 1'b0; cyc(); cyc(); cyc();
    cs_n = 1'b1;
    for (int i = 0; i < 8; i++) cyc();
    // R8: command clears, code 10 latched -> floating
    cur_req = "R8";
    cs_n = 1'b0; cyc();
    cmd_strobe = 1'b1; cyc(); cmd_strobe = 1'b0;
    cs_n = 1'b1;
    for (int i = 0; i < 10; i++) cyc();
    // R10: sequencer owns the pin even while floating sleep is latched
    cur_req = "R10";
    seq_busy = 1'b1;
    for (int i = 0; i < 10; i++) begin seq_lvl = i[1]; cyc(); end
    seq_busy = 1'b0;
    cyc(); cyc();
    // R8: code 11 behaves as no sleep
    cur_req = "R8";
    sleep_code = 2'b11;
    cs_n = 1'b0; cyc();
    cmd_strobe = 1'b1; cyc(); cmd_strobe = 1'b0;
    cs_n = 1'b1;
    for (int i = 0; i < 10; i++) cyc();
    sleep_code = 2'b00;
    // R10: sequencer owns the pin inside a frame
    cur_req = "R10";
    seq_busy = 1'b1;
    run_frame("R10", 12, 1, 1'b0, 1'b0, 1'b1, 1'b1);
    seq_busy = 1'b0;
    run_frame("R2", 2, 1, 1'b0, 1'b0, 1'b0, 1'b1);
    cur_req = "R2";
    for (int i = 0; i < 10; i++) cyc();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule